// File: doc/BRIEF.md
# Rate, Bandwidth and Power-Down Controller

This block sits between a reference clock and a majority-vote noise filter for demodulated binary data. It turns a two-bit rate code into two things: a sample-enable strobe that divides the reference clock by 4, 2 or 1, and a flag that tells the filter to vote over a half-size window. It also sequences power-down. While the enable input is low, no strobes are produced and the data pin driver is turned off. When enable returns, a one-cycle filter reset is produced before sampling resumes.

The internal reset is timed in reference cycles from the edge at which enable is first seen high. The strobe divider is cleared by that reset, so the first strobe always lands a fixed number of cycles after the filter starts running. The half-window code may only be entered or left while the block is powered down. Any such change while enabled sets a sticky error flag, and the next power-down clears it. All other code changes are legal at any time.

Top module: `rate_bw_ctrl`

## Requirements
- R1: With `rate_sel` = 2'b00 the strobe is high on one cycle in four. The first strobe is on run cycle 3, where run cycle 0 is the first cycle with `dout_oe` high. `dbl_bw` is low in this mode.
- R2: With `rate_sel` = 2'b10 the strobe is high on every other cycle, on odd run cycles (1, 3, 5, ...). `dbl_bw` is low in this mode.
- R3: With `rate_sel` = 2'b11 the strobe is high on every run cycle and `dbl_bw` is low.
- R4: With `rate_sel` = 2'b01 the strobe is high on every run cycle and `dbl_bw` is high while `en` is high.
- R5: `dbl_bw` is low whenever `en` is low, whatever the value of `rate_sel`.
- R6: From the first clock edge that samples `en` low, `sample_stb`, `dout_oe` and `filt_rst` stay low until the power-up sequence completes again.
- R7: Let `en` be sampled high at edge k while powered down. Then `filt_rst` is high for exactly the one cycle after edge k+1, and `dout_oe` rises after edge k+2, which begins run cycle 0.
- R8: After the synchronous reset `rst`, `en` must be sampled low on at least one edge before any power-up sequence. If `en` is already high, `filt_rst` and `dout_oe` stay low until `en` has been low.
- R9: Changes of `rate_sel` among 2'b00, 2'b10 and 2'b11 while enabled do not set `mode_err`, and the new strobe rate applies at once.
- R10: Suppose `en` is high on two consecutive edges and the membership of `rate_sel` in code 2'b01 differs between them. Then `mode_err` goes high after the second of those edges. It stays high while `en` is high and clears after the first edge that samples `en` low.
- R11: While `rst` is high at an edge, the block enters power-down: `sample_stb`, `filt_rst`, `dout_oe` and `mode_err` are low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low requests power-down |
| rate_sel | input | 2 | Rate/bandwidth code: bit 1 and bit 0 as in R1 to R4 |
| sample_stb | output | 1 | Sample-enable strobe for the filter |
| dbl_bw | output | 1 | Half-window (double bandwidth) flag |
| filt_rst | output | 1 | One-cycle filter reset |
| dout_oe | output | 1 | Data pin driver enable |
| mode_err | output | 1 | Sticky illegal-mode-change flag |

## Verification
The assertions assume that `en` and `rate_sel` are synchronous to the reference clock and change only between edges. They also assume that `rate_sel` holds still across the cycle after a divide-by-four strobe, unless the check allows for a mode change. The stimulus drives every input one time unit after a rising edge and samples outputs a unit later. The divide-by-four spacing check is written to tolerate a rate change on the following cycle, which the R9 test makes deliberately.

// File: rtl/rate_bw_pkg.sv
package rate_bw_pkg;

    typedef enum logic [1:0] {
        PS_OFF = 2'd0,
        PS_ARM = 2'd1,
        PS_CLR = 2'd2,
        PS_RUN = 2'd3
    } pwr_state_t;

    localparam logic [1:0] CODE_SLOW = 2'b00;
    localparam logic [1:0] CODE_MID  = 2'b10;
    localparam logic [1:0] CODE_HALF = 2'b01;
    localparam logic [1:0] CODE_FAST = 2'b11;

    function automatic logic is_half_window(input logic [1:0] code);
        return code == CODE_HALF;
    endfunction

endpackage

// File: rtl/rate_divider.sv
module rate_divider
    import rate_bw_pkg::*;
#(
    parameter int SLOW_LOG2 = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic [1:0] code_i,
    output logic       stb_o
);
    localparam int CW = (SLOW_LOG2 < 1) ? 1 : SLOW_LOG2;
    localparam logic [CW-1:0] MASK_SLOW = {CW{1'b1}};
    localparam logic [CW-1:0] MASK_MID  = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] mask;

    always_comb begin
        unique case (code_i)
            CODE_SLOW: mask = MASK_SLOW;
            CODE_MID:  mask = MASK_MID;
            default:   mask = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stb_o = run_i && ((cnt_q & mask) == mask);

    // R1: a divide-by-four strobe is never followed by another unless the rate changed
    a_r1_slow_gap: assert property (@(posedge clk) disable iff (rst)
        (stb_o && code_i == CODE_SLOW) |=> (!stb_o || code_i != CODE_SLOW));

endmodule

// File: rtl/power_seq.sv
module power_seq
    import rate_bw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic clr_o,
    output logic run_o
);
    pwr_state_t state_q, state_d;
    logic       seen_low_q;

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = PS_OFF;
        end else begin
            unique case (state_q)
                PS_OFF: if (seen_low_q) state_d = PS_ARM;
                PS_ARM: state_d = PS_CLR;
                PS_CLR: state_d = PS_RUN;
                PS_RUN: state_d = PS_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PS_OFF;
            seen_low_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!en_i) seen_low_q <= 1'b1;
        end
    end

    assign clr_o = (state_q == PS_CLR);
    assign run_o = (state_q == PS_RUN);

    // R7: the filter reset lasts one cycle
    a_r7_clr_single: assert property (@(posedge clk) disable iff (rst)
        clr_o |=> !clr_o);
    // R7: the reset is followed by running when enable holds
    a_r7_clr_to_run: assert property (@(posedge clk) disable iff (rst)
        (clr_o && en_i) |=> run_o);
    // R6: enable low shuts everything off on the next cycle
    a_r6_off: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!run_o && !clr_o));

endmodule

// File: rtl/mode_guard.sv
module mode_guard
    import rate_bw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic [1:0] code_i,
    output logic       err_o
);
    logic en_q;
    logic half_q;
    logic half_now;
    logic viol;

    assign half_now = is_half_window(code_i);
    assign viol     = en_i && en_q && (half_now != half_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            half_q <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            en_q   <= en_i;
            half_q <= half_now;
            err_o  <= en_i ? (err_o || viol) : 1'b0;
        end
    end

    // R10: the flag is sticky while enabled
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_o && en_i) |=> err_o);
    // R10: power-down clears the flag
    a_r10_err_clear: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !err_o);

endmodule

// File: rtl/rate_bw_ctrl.sv
module rate_bw_ctrl
    import rate_bw_pkg::*;
#(
    parameter int SLOW_LOG2 = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] rate_sel,
    output logic       sample_stb,
    output logic       dbl_bw,
    output logic       filt_rst,
    output logic       dout_oe,
    output logic       mode_err
);
    logic run;
    logic clr;

    power_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .en_i  (en),
        .clr_o (clr),
        .run_o (run)
    );

    rate_divider #(.SLOW_LOG2(SLOW_LOG2)) u_div (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .clr_i  (clr),
        .code_i (rate_sel),
        .stb_o  (sample_stb)
    );

    mode_guard u_guard (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en),
        .code_i (rate_sel),
        .err_o  (mode_err)
    );

    assign dbl_bw   = en && is_half_window(rate_sel);
    assign filt_rst = clr;
    assign dout_oe  = run;

    // R6: strobes only while the output is driven
    a_r6_stb_needs_oe: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> dout_oe);
    // R7: reset pulse and driven output never overlap
    a_r7_excl: assert property (@(posedge clk) disable iff (rst)
        !(filt_rst && dout_oe));

endmodule

// File: tb/rate_bw_ctrl_tb.sv
module rate_bw_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic [1:0] rate_sel;
    logic       sample_stb, dbl_bw, filt_rst, dout_oe, mode_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rate_bw_ctrl u_dut (
        .clk(clk), .rst(rst), .en(en), .rate_sel(rate_sel),
        .sample_stb(sample_stb), .dbl_bw(dbl_bw), .filt_rst(filt_rst),
        .dout_oe(dout_oe), .mode_err(mode_err)
    );

    // {code, expected dbl_bw, strobe pattern for run cycles 7..0}
    localparam int NV = 4;
    localparam logic [10:0] VEC [NV] = '{
        {2'b00, 1'b0, 8'b1000_1000},  // R1
        {2'b10, 1'b0, 8'b1010_1010},  // R2
        {2'b11, 1'b0, 8'b1111_1111},  // R3
        {2'b01, 1'b1, 8'b1111_1111}   // R4
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        #1;
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // power down for two edges then sequence up; ends at run cycle 0
    task automatic power_up(input string req);
        en = 1'b0;
        tick(); tick();
        en = 1'b1;
        tick();                 // edge k
        chk(req, filt_rst, 0);
        tick();                 // edge k+1
        chk(req, filt_rst, 1);
        chk(req, dout_oe, 0);
        tick();                 // edge k+2
        chk(req, filt_rst, 0);
        chk(req, dout_oe, 1);
    endtask

    initial begin
        #150000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; en = 1'b0; rate_sel = 2'b00;
        tick(); tick();
        // R11 reset state
        chk("R11", sample_stb, 0);
        chk("R11", filt_rst, 0);
        chk("R11", dout_oe, 0);
        chk("R11", mode_err, 0);
        rst = 1'b0;

        // vector table
        for (int v = 0; v < NV; v++) begin
            rate_sel = VEC[v][10:9];
            power_up("R7");
            for (int i = 0; i < 8; i++) begin
                chk(v == 0 ? "R1" : v == 1 ? "R2" : v == 2 ? "R3" : "R4",
                    sample_stb, int'(VEC[v][i]));
                chk(v == 3 ? "R4" : "R3", dbl_bw, int'(VEC[v][8]));
                tick();
            end
            chk("R10", mode_err, 0);
        end

        // R5: half-window code with enable low
        en = 1'b0; rate_sel = 2'b01;
        tick();
        chk("R5", dbl_bw, 0);
        // R6: drop enable mid-run
        rate_sel = 2'b11;
        power_up("R7");
        chk("R6", sample_stb, 1);
        en = 1'b0;
        tick();
        chk("R6", sample_stb, 0);
        chk("R6", dout_oe, 0);
        tick();
        chk("R6", filt_rst, 0);

        // R9: legal changes while enabled
        rate_sel = 2'b00;
        power_up("R7");
        tick(); tick(); tick();          // run cycle 3
        chk("R9", sample_stb, 1);
        rate_sel = 2'b11;
        chk("R9", sample_stb, 1);        // immediate
        tick();
        rate_sel = 2'b10;
        tick(); tick();
        chk("R9", mode_err, 0);

        // R10: illegal change while enabled
        rate_sel = 2'b01;
        tick();
        chk("R10", mode_err, 1);
        rate_sel = 2'b00;
        tick(); tick();
        chk("R10", mode_err, 1);
        en = 1'b0;
        tick();
        chk("R10", mode_err, 0);
        // entering the half code while down is legal
        rate_sel = 2'b01;
        power_up("R7");
        tick();
        chk("R10", mode_err, 0);

        // R8: enable high straight out of reset
        rst = 1'b1; en = 1'b1;
        tick();
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R8", filt_rst, 0);
            chk("R8", dout_oe, 0);
        end
        power_up("R8");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule